// File: doc/BRIEF.md
# Abnormal Charge Current Detector

This block sits in the digital core of a single-cell battery protector. It watches two digitized comparator results and two status flags, and it decides when the charge path must be cut because current is being forced into the pack the wrong way. The two comparator results are the load pin sitting below the charger detection threshold and the discharge gate being on. A fault is declared only when the load-pin condition holds, with the discharge gate on, for a qualifying delay. That delay is measured in ticks of a slow timebase of about 2 kHz, so the nominal 1 s becomes 2000 ticks.

Once declared, the fault is latched and the charge gate stays off until the charger is removed. Removal shows up as the load-pin condition going away. An overdischarged cell keeps the discharge gate off, so detection cannot begin until the cell recovers. When 0 V battery charging is enabled and the cell is overdischarged, the 0 V charging path has priority: detection is suppressed and any latched fault is released.

Top module: `acc_guard`

## Requirements
- R1: Detection is armed only when `chg_below` = 1, `dsg_on` = 1 and the 0 V priority condition of R6 is absent. Only cycles with `tick` = 1 advance the qualifying delay.
- R2: After exactly DELAY_TICKS armed ticks in a row, `fault` goes to 1 on the clock edge that samples the last of those ticks. After fewer ticks it stays 0.
- R3: If the arming condition of R1 drops for even one clock cycle before the delay has expired, the count restarts from zero.
- R4: A latched fault holds whatever `dsg_on` and `tick` do. It is released on the first clock edge at which `chg_below` = 0, which means the charger has been removed.
- R5: Synchronous active-high reset gives `chg_en` = 1 and `fault` = 0, and clears the delay count.
- R6: When `zv_chg_en` = 1 and `odis` = 1, 0 V charging has priority. No delay is counted, and a latched fault is released on the next clock edge.
- R7: `chg_en` is registered and always equals the inverse of `fault`.
- R8: While `odis` = 1 with `dsg_on` = 0, no detection takes place. Counting starts only once `dsg_on` goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse from the ~2 kHz delay timebase |
| chg_below | input | 1 | Load pin below the charger detection threshold |
| dsg_on | input | 1 | Discharge gate drive is on |
| odis | input | 1 | Overdischarge status |
| zv_chg_en | input | 1 | 0 V battery charging is enabled |
| chg_en | output | 1 | Charge gate enable, registered |
| fault | output | 1 | High while the abnormal-charge fault is latched |

## Verification
Several properties are checked on every cycle:
- `chg_en` is always the inverse of `fault`.
- A latched fault is held while the charger stays attached, and is released the cycle after the charger is removed.
- 0 V priority forces the fault clear.
- The fault can only rise on an armed tick.

The exact length of the qualifying delay can only be shown by the bench's scenarios. So can the restart of the count after a one-cycle interruption, and the full gating over every combination of the four condition inputs.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic {
    ST_NORMAL  = 1'b0,
    ST_LATCHED = 1'b1
  } acc_state_e;
endpackage

// File: rtl/acc_qualifier.sv
module acc_qualifier (
  input  logic chg_below,
  input  logic dsg_on,
  input  logic odis,
  input  logic zv_chg_en,
  output logic armed,
  output logic zv_priority
);
  always_comb begin
    zv_priority = zv_chg_en & odis;
    armed       = chg_below & dsg_on & ~zv_priority;
  end
endmodule

// File: rtl/acc_hold_timer.sv
module acc_hold_timer #(
  parameter int DELAY_TICKS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int W = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
  localparam logic [W-1:0] LAST = W'(DELAY_TICKS - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  always_comb expired = run & tick & (cnt == LAST);
endmodule

// File: rtl/acc_fsm.sv
module acc_fsm
  import acc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expired,
  input  logic chg_below,
  input  logic zv_priority,
  output logic normal,
  output logic chg_en,
  output logic fault
);
  acc_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_NORMAL;
      chg_en <= 1'b1;
      fault  <= 1'b0;
    end else begin
      case (state)
        ST_NORMAL: begin
          if (expired) begin
            state  <= ST_LATCHED;
            chg_en <= 1'b0;
            fault  <= 1'b1;
          end
        end
        default: begin
          if (zv_priority || !chg_below) begin
            state  <= ST_NORMAL;
            chg_en <= 1'b1;
            fault  <= 1'b0;
          end
        end
      endcase
    end
  end

  always_comb normal = (state == ST_NORMAL);
endmodule

// File: rtl/acc_guard.sv
module acc_guard #(
  parameter int DELAY_TICKS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic chg_below,
  input  logic dsg_on,
  input  logic odis,
  input  logic zv_chg_en,
  output logic chg_en,
  output logic fault
);
  logic armed, zv_priority, normal, expired;

  acc_qualifier u_qual (
    .chg_below   (chg_below),
    .dsg_on      (dsg_on),
    .odis        (odis),
    .zv_chg_en   (zv_chg_en),
    .armed       (armed),
    .zv_priority (zv_priority)
  );

  acc_hold_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (armed & normal),
    .tick    (tick),
    .expired (expired)
  );

  acc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .expired     (expired),
    .chg_below   (chg_below),
    .zv_priority (zv_priority),
    .normal      (normal),
    .chg_en      (chg_en),
    .fault       (fault)
  );
endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic chg_below,
  input logic dsg_on,
  input logic odis,
  input logic zv_chg_en,
  input logic chg_en,
  input logic fault
);
  p_gate_inverse_r7: assert property (@(posedge clk) disable iff (rst)
    chg_en == !fault);

  p_release_on_removal_r4: assert property (@(posedge clk) disable iff (rst)
    (fault && !chg_below) |=> !fault);

  p_latch_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (fault && chg_below && !(zv_chg_en && odis)) |=> fault);

  p_zero_volt_priority_r6: assert property (@(posedge clk) disable iff (rst)
    (zv_chg_en && odis) |=> !fault);

  p_rise_on_armed_tick_r1: assert property (@(posedge clk) disable iff (rst)
    (!fault && !(tick && chg_below && dsg_on)) |=> !fault);
endmodule

bind acc_guard acc_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .chg_below (chg_below),
  .dsg_on    (dsg_on),
  .odis      (odis),
  .zv_chg_en (zv_chg_en),
  .chg_en    (chg_en),
  .fault     (fault)
);

// File: tb/sim_acc_guard.sv
module sim_acc_guard;
  localparam int D = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, chg_below = 1'b0, dsg_on = 1'b0, odis = 1'b0, zv_chg_en = 1'b0;
  logic chg_en, fault;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_guard #(.DELAY_TICKS(D)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .chg_below(chg_below), .dsg_on(dsg_on),
    .odis(odis), .zv_chg_en(zv_chg_en), .chg_en(chg_en), .fault(fault)
  );

  task automatic check(input string req, input logic exp_fault);
    checks++;
    if (fault !== exp_fault || chg_en !== !exp_fault) begin
      errors++;
      $display("FAIL %s: fault=%b chg_en=%b expected fault=%b chg_en=%b",
               req, fault, chg_en, exp_fault, !exp_fault);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    chg_below = 1'b0; dsg_on = 1'b0; odis = 1'b0; zv_chg_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R5 after reset", 1'b0);

    // R2: sweep run lengths around the delay
    for (int n = 1; n <= D + 2; n++) begin
      @(negedge clk); chg_below = 1'b1; dsg_on = 1'b1;
      ticks(n);
      check($sformatf("R2 run of %0d ticks", n), n >= D);
      @(negedge clk); chg_below = 1'b0;
      @(negedge clk);
      check("R4 release on removal", 1'b0);
      settle();
    end

    // R1/R6/R8: all condition combinations for a full delay
    for (int c = 0; c < 16; c++) begin
      logic e;
      @(negedge clk);
      chg_below = c[0]; dsg_on = c[1]; odis = c[2]; zv_chg_en = c[3];
      ticks(D);
      e = c[0] & c[1] & ~(c[2] & c[3]);
      check($sformatf("R1 R6 R8 combo %0d", c), e);
      settle();
    end

    // R8: overdischarge holds off, count begins after recovery
    @(negedge clk); chg_below = 1'b1; odis = 1'b1; dsg_on = 1'b0;
    ticks(D + 3);
    check("R8 held off while discharge gate low", 1'b0);
    @(negedge clk); odis = 1'b0; dsg_on = 1'b1;
    ticks(D - 1);
    check("R8 not yet after recovery", 1'b0);
    ticks(1);
    check("R8 fault after recovery delay", 1'b1);
    settle();

    // R3: one-cycle interruption restarts the count
    @(negedge clk); chg_below = 1'b1; dsg_on = 1'b1;
    ticks(D - 1);
    @(negedge clk); dsg_on = 1'b0;
    @(negedge clk); dsg_on = 1'b1;
    ticks(D - 1);
    check("R3 restart after interruption", 1'b0);
    ticks(1);
    check("R3 full delay after restart", 1'b1);

    // R4: latched fault ignores discharge gate and ticks
    @(negedge clk); dsg_on = 1'b0;
    ticks(D + 2);
    check("R4 hold with discharge gate low", 1'b1);
    @(negedge clk); chg_below = 1'b0;
    @(negedge clk);
    check("R4 released next edge", 1'b0);
    settle();

    // R6: 0 V priority releases a latched fault
    @(negedge clk); chg_below = 1'b1; dsg_on = 1'b1;
    ticks(D);
    check("R6 latched before priority", 1'b1);
    @(negedge clk); odis = 1'b1; zv_chg_en = 1'b1;
    @(negedge clk);
    check("R6 priority release", 1'b0);
    settle();

    // R5: reset clears a latched fault and the count
    @(negedge clk); chg_below = 1'b1; dsg_on = 1'b1;
    ticks(D);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R5 reset clears fault", 1'b0);
    ticks(D - 1);
    check("R5 count cleared by reset", 1'b0);
    ticks(1);
    check("R2 R7 full delay after reset", 1'b1);
    settle();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule